// File: doc/BRIEF.md
# Electron/Photon Isolation Finder

This block scans one 4x4 region of calorimeter trigger towers and reports its best electron/photon candidates. Each tower carries an electromagnetic transverse-energy value and two precomputed flags. One flag marks a failed shower-shape (fine-grain) test. The other marks a failed hadronic-over-EM test. The block sees a 6x6 tower grid: the 16 region towers plus the ring of towers around them. Every region tower therefore has a full 3x3 neighbourhood.

Each region tower is tried as a hit tower. The candidate energy is the hit tower plus its largest edge-sharing neighbour. The candidate is then classed as isolated or non-isolated from its eight surrounding towers. Two winners are kept, one isolated and one non-isolated, each chosen by energy. Their energies are converted to a 6-bit rank through a 512-entry table that is written through a simple write port. The results are registered and appear one clock after the grid is presented.

Grid tower (row, col), with rows and columns 0..5, sits at index row*6+col. Its energy is the 8-bit field at bits [index*8 +: 8] of the energy bus. Region position p = r*4+c (row-major, r,c in 0..3) maps to grid tower (r+1, c+1).

Top module: `egiso_finder`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output register clears to zero. This covers `res_valid_o`, both found flags, both positions and both ranks.
- R2: A grid presented with `nbhd_valid_i` high at a rising edge produces its results on that edge, and `res_valid_o` is high for exactly the following cycle. A rising edge with `nbhd_valid_i` low leaves the found, position and rank outputs unchanged, whatever the other inputs hold.
- R3: A region tower is a candidate only if three conditions all hold: its energy is non-zero, its fine-grain fail bit is 0, and its H/E fail bit is 0.
- R4: The candidate energy is the hit tower energy plus the largest of its four edge-sharing neighbours (north, south, east, west). Diagonal towers never enter the sum. The result is a 9-bit value, so 255+255 gives 510.
- R5: A candidate is isolated only if both of the following hold. First, all eight surrounding towers have both fail bits at 0. Second, at least one of four five-tower L groups has a summed energy strictly below `iso_thr_i`. Each L group is one corner of the 3x3 neighbourhood plus the full row and the full column through that corner, excluding the centre.
- R6: `iso_found_o` and `iso_pos_o` identify the isolated candidate with the largest energy.
- R7: `nonis_found_o` and `nonis_pos_o` identify the non-isolated candidate with the largest energy. If there is no non-isolated candidate, they report the isolated winner instead.
- R8: When several candidates share the largest energy, the one with the lower position p wins.
- R9: Each rank output equals the table entry addressed by its winner's 9-bit energy. A write with `lut_we_i` high at a rising edge stores `lut_data_i` at `lut_addr_i`, and later lookups return the new value.
- R10: When a class has no candidate, its found flag, position and rank all register as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nbhd_valid_i | input | 1 | The grid inputs hold a neighbourhood to evaluate |
| tow_et_i | input | 288 | 36 tower EM energies, 8 bits each, indexed row*6+col |
| tow_fg_fail_i | input | 36 | Per-tower fine-grain test failed |
| tow_hoe_fail_i | input | 36 | Per-tower H/E test failed |
| iso_thr_i | input | 11 | Quiet threshold for the L-group sums |
| lut_we_i | input | 1 | Rank table write enable |
| lut_addr_i | input | 9 | Rank table write address (energy value) |
| lut_data_i | input | 6 | Rank table write data |
| res_valid_o | output | 1 | Results below were updated on the last edge |
| iso_found_o | output | 1 | An isolated candidate exists |
| iso_pos_o | output | 4 | Position of the isolated winner |
| iso_rank_o | output | 6 | Rank of the isolated winner |
| nonis_found_o | output | 1 | A non-isolated (or fall-back) winner exists |
| nonis_pos_o | output | 4 | Position of the non-isolated winner |
| nonis_rank_o | output | 6 | Rank of the non-isolated winner |

## Verification
The first set of directed grids places candidates next to the outer ring, so no neighbour is itself a candidate. These grids separate the edge-only energy sum from a diagonal sum, and the strict threshold compare from a less-or-equal compare. They also show that a single failed flag on a neighbour drops isolation. Two equal-energy candidates at opposite corners check the lower-position tie-break. Changing the classes of those same candidates checks the fall-back from non-isolated to isolated. A table rewrite shows that ranks come from the stored table. Random grids follow, with mostly low energies, sparse fail flags and varying thresholds, so that isolated, non-isolated and empty outcomes all occur often.

// File: rtl/egiso_pkg.sv
// Package egiso_pkg
// Shared constants for the isolation finder: neighbourhood geometry of a
// 3x3 window (index = row*3+col, centre 4) and the four L-shaped groups.
package egiso_pkg;
    localparam int NB_N   = 9;   // towers in a 3x3 window
    localparam int NB_CTR = 4;   // index of the hit tower in the window
    localparam int LG_N   = 4;   // number of L groups
    localparam int LG_LEN = 5;   // towers per L group

    // Each row: a corner, then the rest of its row and column (centre excluded).
    localparam int unsigned LSHAPE [LG_N][LG_LEN] = '{
        '{0, 1, 2, 3, 6},
        '{2, 1, 0, 5, 8},
        '{6, 7, 8, 3, 0},
        '{8, 7, 6, 5, 2}
    };
endpackage

// File: rtl/egiso_cand.sv
// Module egiso_cand
// Evaluates one hit tower from its 3x3 window: candidate eligibility, candidate
// energy (hit + largest edge neighbour) and the isolation class.
// Assumes THR_W is wide enough to hold the sum of five tower energies.
module egiso_cand
    import egiso_pkg::*;
#(
    parameter int ET_W  = 8,
    parameter int THR_W = 11,
    localparam int SUM_W = ET_W + 1
) (
    input  logic [NB_N*ET_W-1:0] nb_et_i,
    input  logic [NB_N-1:0]      nb_fg_fail_i,
    input  logic [NB_N-1:0]      nb_hoe_fail_i,
    input  logic [THR_W-1:0]     thr_i,
    output logic                 ok_o,
    output logic                 iso_o,
    output logic [SUM_W-1:0]     energy_o
);
    logic [ET_W-1:0]  et [NB_N];
    logic [ET_W-1:0]  edge_max;
    logic             ring_clean;
    logic             quiet;

    // Unpack the window energies.
    for (genvar k = 0; k < NB_N; k++) begin : g_unpack
        assign et[k] = nb_et_i[k*ET_W +: ET_W];
    end

    // Largest of the four edge neighbours (odd window indices).
    always_comb begin
        edge_max = '0;
        for (int j = 1; j < NB_N; j += 2) begin
            if (et[j] > edge_max) edge_max = et[j];
        end
    end

    // Candidate energy; the widened sum cannot overflow SUM_W bits.
    assign energy_o = {1'b0, et[NB_CTR]} + {1'b0, edge_max};

    // Hit tower must carry energy and pass both tests.
    assign ok_o = (et[NB_CTR] != '0) && !nb_fg_fail_i[NB_CTR] && !nb_hoe_fail_i[NB_CTR];

    // All eight surrounding towers must pass both tests.
    always_comb begin
        ring_clean = 1'b1;
        for (int k = 0; k < NB_N; k++) begin
            if (k != NB_CTR && (nb_fg_fail_i[k] || nb_hoe_fail_i[k])) ring_clean = 1'b0;
        end
    end

    // At least one L group must sum strictly below the threshold.
    always_comb begin
        logic [THR_W-1:0] grp;
        quiet = 1'b0;
        for (int g = 0; g < LG_N; g++) begin
            grp = '0;
            for (int m = 0; m < LG_LEN; m++) begin
                grp = grp + {{(THR_W-ET_W){1'b0}}, et[LSHAPE[g][m]]};
            end
            if (grp < thr_i) quiet = 1'b1;
        end
    end

    assign iso_o = ok_o && ring_clean && quiet;
endmodule

// File: rtl/egiso_pick.sv
// Module egiso_pick
// Selects the highest-energy entry among the flagged candidates; equal
// energies resolve to the lowest index. Reports index 0 when none is flagged.
module egiso_pick #(
    parameter int N     = 16,
    parameter int E_W   = 9,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     sel_i,
    input  logic [N*E_W-1:0] energy_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [E_W-1:0]   energy_o
);
    // Linear scan; a strict compare keeps the earlier index on ties.
    always_comb begin
        found_o  = 1'b0;
        idx_o    = '0;
        energy_o = '0;
        for (int i = 0; i < N; i++) begin
            if (sel_i[i] && (!found_o || energy_i[i*E_W +: E_W] > energy_o)) begin
                found_o  = 1'b1;
                idx_o    = IDX_W'(i);
                energy_o = energy_i[i*E_W +: E_W];
            end
        end
    end
endmodule

// File: rtl/egiso_rank_lut.sv
// Module egiso_rank_lut
// Energy-to-rank table with one write port and two combinational read ports.
// Contents have no reset; software-style loading is expected before use.
module egiso_rank_lut #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 6,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_a_i,
    input  logic [ADDR_W-1:0] raddr_b_i,
    output logic [DATA_W-1:0] rdata_a_o,
    output logic [DATA_W-1:0] rdata_b_o
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store one entry per write strobe.
    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    // Two independent lookups.
    assign rdata_a_o = mem[raddr_a_i];
    assign rdata_b_o = mem[raddr_b_i];
endmodule

// File: rtl/egiso_finder.sv
// Module egiso_finder (top)
// Evaluates every tower of a SIDE x SIDE region over a (SIDE+2)^2 grid, keeps
// the best isolated and best non-isolated candidate, ranks both through a
// table and registers the results one cycle after the grid is valid.
// Assumes the fine-grain and H/E flags arrive already computed per tower.
module egiso_finder
    import egiso_pkg::*;
#(
    parameter int SIDE   = 4,
    parameter int ET_W   = 8,
    parameter int RANK_W = 6,
    parameter int THR_W  = ET_W + 3,
    localparam int GSIDE  = SIDE + 2,
    localparam int GRID_N = GSIDE * GSIDE,
    localparam int N_CAND = SIDE * SIDE,
    localparam int POS_W  = $clog2(N_CAND),
    localparam int SUM_W  = ET_W + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   nbhd_valid_i,
    input  logic [GRID_N*ET_W-1:0] tow_et_i,
    input  logic [GRID_N-1:0]      tow_fg_fail_i,
    input  logic [GRID_N-1:0]      tow_hoe_fail_i,
    input  logic [THR_W-1:0]       iso_thr_i,
    input  logic                   lut_we_i,
    input  logic [SUM_W-1:0]       lut_addr_i,
    input  logic [RANK_W-1:0]      lut_data_i,
    output logic                   res_valid_o,
    output logic                   iso_found_o,
    output logic [POS_W-1:0]       iso_pos_o,
    output logic [RANK_W-1:0]      iso_rank_o,
    output logic                   nonis_found_o,
    output logic [POS_W-1:0]       nonis_pos_o,
    output logic [RANK_W-1:0]      nonis_rank_o
);
    logic [N_CAND-1:0]       cand_ok;
    logic [N_CAND-1:0]       cand_iso;
    logic [N_CAND*SUM_W-1:0] cand_e;

    // One evaluator per region tower, fed its 3x3 window from the grid.
    for (genvar r = 0; r < SIDE; r++) begin : g_row
        for (genvar c = 0; c < SIDE; c++) begin : g_col
            logic [NB_N*ET_W-1:0] nb_et;
            logic [NB_N-1:0]      nb_fg;
            logic [NB_N-1:0]      nb_hoe;
            for (genvar k = 0; k < NB_N; k++) begin : g_win
                localparam int G = (r + k / 3) * GSIDE + (c + k % 3);
                assign nb_et[k*ET_W +: ET_W] = tow_et_i[G*ET_W +: ET_W];
                assign nb_fg[k]  = tow_fg_fail_i[G];
                assign nb_hoe[k] = tow_hoe_fail_i[G];
            end
            egiso_cand #(.ET_W(ET_W), .THR_W(THR_W)) u_cand (
                .nb_et_i       (nb_et),
                .nb_fg_fail_i  (nb_fg),
                .nb_hoe_fail_i (nb_hoe),
                .thr_i         (iso_thr_i),
                .ok_o          (cand_ok[r*SIDE+c]),
                .iso_o         (cand_iso[r*SIDE+c]),
                .energy_o      (cand_e[(r*SIDE+c)*SUM_W +: SUM_W])
            );
        end
    end

    logic             iso_f, non_f, nsel_f;
    logic [POS_W-1:0] iso_i, non_i, nsel_i;
    logic [SUM_W-1:0] iso_e, non_e, nsel_e;
    logic [RANK_W-1:0] iso_rk, nsel_rk;

    egiso_pick #(.N(N_CAND), .E_W(SUM_W), .IDX_W(POS_W)) u_pick_iso (
        .sel_i    (cand_ok & cand_iso),
        .energy_i (cand_e),
        .found_o  (iso_f),
        .idx_o    (iso_i),
        .energy_o (iso_e)
    );

    egiso_pick #(.N(N_CAND), .E_W(SUM_W), .IDX_W(POS_W)) u_pick_non (
        .sel_i    (cand_ok & ~cand_iso),
        .energy_i (cand_e),
        .found_o  (non_f),
        .idx_o    (non_i),
        .energy_o (non_e)
    );

    // Fall back to the isolated winner when no non-isolated candidate exists.
    always_comb begin
        if (non_f) begin
            nsel_f = 1'b1;
            nsel_i = non_i;
            nsel_e = non_e;
        end else begin
            nsel_f = iso_f;
            nsel_i = iso_i;
            nsel_e = iso_e;
        end
    end

    egiso_rank_lut #(.ADDR_W(SUM_W), .DATA_W(RANK_W)) u_lut (
        .clk       (clk),
        .we_i      (lut_we_i),
        .waddr_i   (lut_addr_i),
        .wdata_i   (lut_data_i),
        .raddr_a_i (iso_e),
        .raddr_b_i (nsel_e),
        .rdata_a_o (iso_rk),
        .rdata_b_o (nsel_rk)
    );

    // Register the two winners when a grid is valid; hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid_o   <= 1'b0;
            iso_found_o   <= 1'b0;
            iso_pos_o     <= '0;
            iso_rank_o    <= '0;
            nonis_found_o <= 1'b0;
            nonis_pos_o   <= '0;
            nonis_rank_o  <= '0;
        end else begin
            res_valid_o <= nbhd_valid_i;
            if (nbhd_valid_i) begin
                iso_found_o   <= iso_f;
                iso_pos_o     <= iso_f ? iso_i : '0;
                iso_rank_o    <= iso_f ? iso_rk : '0;
                nonis_found_o <= nsel_f;
                nonis_pos_o   <= nsel_f ? nsel_i : '0;
                nonis_rank_o  <= nsel_f ? nsel_rk : '0;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> res_valid_o == $past(nbhd_valid_i)); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(nbhd_valid_i)) |->
        ($stable(iso_rank_o) && $stable(nonis_rank_o) && $stable(iso_pos_o) && $stable(nonis_pos_o))); // R2
    AST_ISO_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !iso_found_o |-> (iso_rank_o == '0 && iso_pos_o == '0)); // R10
    AST_NON_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !nonis_found_o |-> (nonis_rank_o == '0 && nonis_pos_o == '0)); // R10
    AST_FALLBACK_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        iso_found_o |-> nonis_found_o); // R7
endmodule

// File: tb/egiso_finder_tb.sv
`timescale 1ns/1ps
module egiso_finder_tb;
    localparam int GN = 36;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nbhd_valid = 1'b0;
    logic [GN*8-1:0] tow_et = '0;
    logic [GN-1:0] tow_fg = '0, tow_he = '0;
    logic [10:0] thr = '0;
    logic lut_we = 1'b0;
    logic [8:0] lut_addr = '0;
    logic [5:0] lut_data = '0;
    logic res_valid, iso_found, nonis_found;
    logic [3:0] iso_pos, nonis_pos;
    logic [5:0] iso_rank, nonis_rank;

    always #10 clk = ~clk;

    egiso_finder u_dut (
        .clk(clk), .rst_n(rst_n), .nbhd_valid_i(nbhd_valid),
        .tow_et_i(tow_et), .tow_fg_fail_i(tow_fg), .tow_hoe_fail_i(tow_he),
        .iso_thr_i(thr), .lut_we_i(lut_we), .lut_addr_i(lut_addr), .lut_data_i(lut_data),
        .res_valid_o(res_valid), .iso_found_o(iso_found), .iso_pos_o(iso_pos),
        .iso_rank_o(iso_rank), .nonis_found_o(nonis_found), .nonis_pos_o(nonis_pos),
        .nonis_rank_o(nonis_rank)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    int g_et [GN];
    bit g_fg [GN], g_he [GN];
    int tbl [512];
    int LS [4][5] = '{'{0,1,2,3,6}, '{2,1,0,5,8}, '{6,7,8,3,0}, '{8,7,6,5,2}};
    int e_if, e_ip, e_ir, e_nf, e_np, e_nr;

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int nbi(int r, int c, int k);
        return (r + k / 3) * 6 + (c + k % 3);
    endfunction

    task automatic clear_grid();
        for (int i = 0; i < GN; i++) begin g_et[i] = 0; g_fg[i] = 0; g_he[i] = 0; end
    endtask

    task automatic push();
        for (int i = 0; i < GN; i++) begin
            tow_et[i*8 +: 8] = g_et[i][7:0];
            tow_fg[i] = g_fg[i];
            tow_he[i] = g_he[i];
        end
    endtask

    // Reference model built from R3..R10.
    task automatic model();
        bit ok [16];
        bit iso [16];
        int en [16];
        int bi, bn, ei, en_n;
        for (int p = 0; p < 16; p++) begin
            int r = p / 4, c = p % 4, h, mx, s;
            bit clean, quiet;
            h = g_et[nbi(r, c, 4)];
            ok[p] = (h != 0) && !g_fg[nbi(r, c, 4)] && !g_he[nbi(r, c, 4)];
            mx = 0;
            for (int k = 1; k < 9; k += 2) if (g_et[nbi(r, c, k)] > mx) mx = g_et[nbi(r, c, k)];
            en[p] = h + mx;
            clean = 1;
            for (int k = 0; k < 9; k++)
                if (k != 4 && (g_fg[nbi(r, c, k)] || g_he[nbi(r, c, k)])) clean = 0;
            quiet = 0;
            for (int g = 0; g < 4; g++) begin
                s = 0;
                for (int m = 0; m < 5; m++) s += g_et[nbi(r, c, LS[g][m])];
                if (s < int'(thr)) quiet = 1;
            end
            iso[p] = ok[p] && clean && quiet;
        end
        bi = -1; bn = -1; ei = 0; en_n = 0;
        for (int p = 0; p < 16; p++) begin
            if (ok[p] && iso[p] && (bi < 0 || en[p] > ei)) begin bi = p; ei = en[p]; end
            if (ok[p] && !iso[p] && (bn < 0 || en[p] > en_n)) begin bn = p; en_n = en[p]; end
        end
        if (bn < 0) begin bn = bi; en_n = ei; end
        e_if = (bi >= 0); e_ip = (bi >= 0) ? bi : 0; e_ir = (bi >= 0) ? tbl[ei] : 0;
        e_nf = (bn >= 0); e_np = (bn >= 0) ? bn : 0; e_nr = (bn >= 0) ? tbl[en_n] : 0;
    endtask

    task automatic apply(string req);
        @(negedge clk);
        push();
        nbhd_valid = 1'b1;
        model();
        @(negedge clk);
        nbhd_valid = 1'b0;
        chk("R2", {req, " res_valid"}, res_valid, 1);
        chk(req, "iso_found", iso_found, e_if);
        chk(req, "iso_pos", iso_pos, e_ip);
        chk(req, "iso_rank", iso_rank, e_ir);
        chk(req, "nonis_found", nonis_found, e_nf);
        chk(req, "nonis_pos", nonis_pos, e_np);
        chk(req, "nonis_rank", nonis_rank, e_nr);
    endtask

    task automatic lut_write(int a, int d);
        @(negedge clk);
        lut_we = 1'b1; lut_addr = a[8:0]; lut_data = d[5:0];
        tbl[a] = d;
        @(negedge clk);
        lut_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        clear_grid();
        // R1: reset clears outputs
        repeat (3) @(negedge clk);
        chk("R1", "res_valid", res_valid, 0);
        chk("R1", "iso_found", iso_found, 0);
        chk("R1", "nonis_found", nonis_found, 0);
        chk("R1", "iso_rank", iso_rank, 0);
        chk("R1", "nonis_pos", nonis_pos, 0);
        rst_n = 1'b1;

        for (int a = 0; a < 512; a++) begin
            @(negedge clk);
            lut_we = 1'b1; lut_addr = a[8:0]; lut_data = 6'($urandom % 64);
            tbl[a] = int'(lut_data);
        end
        @(negedge clk); lut_we = 1'b0;

        // R10: empty grid
        clear_grid(); thr = 11'd100;
        apply("R10");

        // R3/R4: hit at p0 with outer N and W, big diagonal excluded
        clear_grid();
        g_et[7] = 50; g_et[1] = 20; g_et[6] = 20; g_et[0] = 100;
        thr = 11'd1;
        apply("R4");
        chk("R4", "edge-only energy rank", iso_rank, tbl[70]);
        // R5: threshold strictly below (min group sum is 0)
        thr = 11'd0;
        apply("R5");
        chk("R5", "thr equal -> not isolated", iso_found, 0);
        // R5: a failed flag on one neighbour breaks isolation
        thr = 11'd1; g_he[0] = 1;
        apply("R5");
        chk("R5", "neighbour fail -> nonis pos", nonis_pos, 0);
        g_he[0] = 0;
        // R3: failed fine-grain on the hit tower -> no candidate
        g_fg[7] = 1;
        apply("R3");
        g_fg[7] = 0;
        // R4: 255 + 255 = 510 without wrap
        g_et[7] = 255; g_et[1] = 255;
        apply("R4");
        chk("R4", "max sum rank", iso_rank, tbl[510]);

        // R8: equal energies at p0 and p15
        clear_grid(); thr = 11'd1;
        g_et[7] = 50; g_et[1] = 20;
        g_et[28] = 50; g_et[34] = 20;
        apply("R8");
        chk("R8", "tie to lower pos", iso_pos, 0);
        chk("R7", "fallback to isolated", nonis_pos, 0);
        // R6: higher energy wins
        g_et[28] = 51;
        apply("R6");
        chk("R6", "iso higher energy", iso_pos, 15);
        // R7: p15 non-isolated, p0 isolated
        g_fg[35] = 1;
        apply("R7");
        chk("R7", "nonis pos", nonis_pos, 15);
        chk("R7", "iso pos", iso_pos, 0);

        // R9: rewrite a table entry and look it up
        lut_write(71, (tbl[71] + 17) % 64);
        apply("R9");
        chk("R9", "rewritten rank", nonis_rank, tbl[71]);

        // R2: idle edge with changed inputs keeps the results
        @(negedge clk);
        clear_grid(); g_et[14] = 90; push(); thr = 11'd500;
        @(negedge clk);
        chk("R2", "idle res_valid", res_valid, 0);
        chk("R2", "idle iso_pos", iso_pos, e_ip);
        chk("R2", "idle nonis_pos", nonis_pos, e_np);
        chk("R2", "idle nonis_rank", nonis_rank, e_nr);

        // Random grids
        for (int v = 0; v < 400; v++) begin
            for (int i = 0; i < GN; i++) begin
                g_et[i] = ($urandom % 5 == 0) ? int'($urandom % 256) : int'($urandom % 24);
                g_fg[i] = ($urandom % 10 == 0);
                g_he[i] = ($urandom % 12 == 0);
            end
            thr = 11'(10 + $urandom % 200);
            apply("R6");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule